// File: doc/BRIEF.md
# Timer Time-Base with Repetition Counter

This block is the counting core of a general-purpose peripheral timer. A programmable divider slows the input clock down. A 16-bit up-counter steps on each divided tick and wraps to zero after it reaches the reload limit. Each wrap is an overflow, and overflows pass through an 8-bit repetition counter. An update event therefore fires only once every REP+1 overflows. On each update event the block raises a one-clock pulse and sets a sticky interrupt flag.

Software programs the block through a plain write port: a select code, a data word and a strobe. The divider value and the repetition value are held pending and take effect only at the next update event. The counter and the reload limit change at once. A software update input forces an update event at once. It restarts the count from zero and loads the pending values. All pins are plain control and status signals. No streamed data passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `tmr_timebase`

## Requirements
- R1: After reset, the count is 0, the update pulse is 0 and the flag is 0. The reload limit resets to 0xFFFF, and the divider and repetition values reset to 0.
- R2: While enabled, the count advances once every PSC+1 clocks, where PSC is the active divider value.
- R3: The count steps from 0 up to the reload limit. On the next tick it returns to 0, and that step is an overflow.
- R4: While the reload limit is 0, the count does not change and no overflow happens.
- R5: An update event fires on every (REP+1)-th overflow. The update pulse is high for one clock after the event edge, so the event period is (REP+1)*(LIMIT+1)*(PSC+1) clocks.
- R6: A repetition value written with select code 3 is held pending. It first governs the overflow run that starts after the next update event.
- R7: A divider value written with select code 1 is held pending. It becomes active only at the next update event, and the divider restarts at that event.
- R8: A high `sw_update` causes an update event on that edge. The count and the divider go to 0, the pending values load, and the pulse and flag are raised.
- R9: The flag is sticky. A write with select code 4 and data bit 0 equal to 0 clears it. A write with bit 0 equal to 1 leaves it unchanged. If an update event happens on the same edge as a clear, the flag ends up set.
- R10: While `cnt_en` is low, the count and the divider hold their values. Counting resumes from those values when `cnt_en` goes high again.
- R11: A write with select code 0 loads the count at once, and counting continues upward from the loaded value. Select code 2 writes the reload limit, which also takes effect at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write select: 0 count, 1 divider, 2 reload limit, 3 repetition, 4 flag |
| wr_data | input | 16 | Write data (the repetition value uses bits 7:0) |
| cnt_en | input | 1 | Count enable |
| sw_update | input | 1 | Software-forced update event |
| count | output | 16 | Live counter value |
| update_pulse | output | 1 | One-clock update-event pulse |
| update_flag | output | 1 | Sticky update interrupt flag |

## Verification
Every result is registered once. A write, a tick or a forced update that is applied at a rising edge shows up on `count`, `update_pulse` and `update_flag` just after that edge. The bench drives inputs on falling edges and samples on the next falling edge, so each sample sits half a clock after the edge that produced it. In the sweep, the cycle index k starts at 0 on the sample right after a forced update. At each sample the bench expects the count to be floor(k/(PSC+1)) mod (LIMIT+1), and it expects the pulse exactly when k is a multiple of the event period. For the pending-value tests it counts the single write cycle into k, so the old value still sets the first interval and the new value sets the next one.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [2:0] {
    SEL_COUNT  = 3'd0,
    SEL_PRESC  = 3'd1,
    SEL_RELOAD = 3'd2,
    SEL_REPEAT = 3'd3,
    SEL_FLAG   = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         psc_wr,
  input  logic [W-1:0] psc_data,
  input  logic         upd,
  output logic         tick
);
  localparam logic [W-1:0] ONE = W'(1);
  logic [W-1:0] pend_q, act_q, div_q;

  assign tick = en && (div_q == act_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
      div_q  <= '0;
    end else begin
      if (psc_wr) pend_q <= psc_data;
      if (upd) begin
        act_q <= pend_q;
        div_q <= '0;
      end else if (en) begin
        div_q <= (div_q == act_q) ? '0 : div_q + ONE;
      end
    end
  end

  // the divider never runs past the active divider value
  assert_div_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    div_q <= act_q);
  // a pending divider value stays out of the active one until an update
  assert_psc_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(act_q));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         swu,
  input  logic         cnt_wr,
  input  logic         lim_wr,
  input  logic [W-1:0] data,
  output logic [W-1:0] count,
  output logic         ovf
);
  localparam logic [W-1:0] ONE = W'(1);
  logic [W-1:0] lim_q;
  logic         lim_zero;

  assign lim_zero = (lim_q == '0);
  assign ovf = tick && !lim_zero && (count >= lim_q) && !swu && !cnt_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      lim_q <= '1;
    end else begin
      if (lim_wr) lim_q <= data;
      if (swu)                     count <= '0;
      else if (cnt_wr)             count <= data;
      else if (tick && !lim_zero)  count <= (count >= lim_q) ? '0 : count + ONE;
    end
  end

  assert_wrap_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (count == '0));
  assert_zero_limit_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_zero && !lim_wr && !swu && !cnt_wr) |=> $stable(count));
endmodule

// File: rtl/tmr_repeat.sv
module tmr_repeat #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ovf,
  input  logic         swu,
  input  logic         rep_wr,
  input  logic [W-1:0] rep_data,
  output logic         upd
);
  localparam logic [W-1:0] ONE = W'(1);
  logic [W-1:0] pend_q, left_q;

  assign upd = swu || (ovf && (left_q == '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      left_q <= '0;
    end else begin
      if (rep_wr) pend_q <= rep_data;
      if (upd)      left_q <= pend_q;
      else if (ovf) left_q <= left_q - ONE;
    end
  end

  // a write alone never disturbs the running repetition count
  assert_rep_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_wr && !ovf && !swu) |=> $stable(left_q));
endmodule

// File: rtl/tmr_timebase.sv
module tmr_timebase
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int REP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             cnt_en,
  input  logic             sw_update,
  output logic [CNT_W-1:0] count,
  output logic             update_pulse,
  output logic             update_flag
);
  logic tick, ovf, upd;
  logic w_cnt, w_psc, w_lim, w_rep, w_flag;

  assign w_cnt  = wr_en && (wr_sel == SEL_COUNT);
  assign w_psc  = wr_en && (wr_sel == SEL_PRESC);
  assign w_lim  = wr_en && (wr_sel == SEL_RELOAD);
  assign w_rep  = wr_en && (wr_sel == SEL_REPEAT);
  assign w_flag = wr_en && (wr_sel == SEL_FLAG);

  tmr_prescaler #(.W(CNT_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .en(cnt_en), .psc_wr(w_psc),
    .psc_data(wr_data), .upd(upd), .tick(tick));

  tmr_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .swu(sw_update),
    .cnt_wr(w_cnt), .lim_wr(w_lim), .data(wr_data),
    .count(count), .ovf(ovf));

  tmr_repeat #(.W(REP_W)) u_rep (
    .clk(clk), .rst_n(rst_n), .ovf(ovf), .swu(sw_update),
    .rep_wr(w_rep), .rep_data(wr_data[REP_W-1:0]), .upd(upd));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      update_pulse <= 1'b0;
      update_flag  <= 1'b0;
    end else begin
      update_pulse <= upd;
      if (upd)                      update_flag <= 1'b1;
      else if (w_flag && !wr_data[0]) update_flag <= 1'b0;
    end
  end

  assert_pulse_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    update_pulse |-> update_flag);
  assert_sw_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sw_update |=> (update_pulse && count == '0));
  assert_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !wr_en && !sw_update) |=> $stable(count));
endmodule

// File: tb/sim_tmr_timebase.sv
module sim_tmr_timebase;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = 3'd0;
  logic [15:0] wr_data = 16'd0;
  logic        cnt_en = 1'b0;
  logic        sw_update = 1'b0;
  logic [15:0] count;
  logic        update_pulse, update_flag;
  int total = 0, bad = 0, cyc = 0;

  always #10 clk = ~clk;

  tmr_timebase u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .cnt_en(cnt_en), .sw_update(sw_update),
    .count(count), .update_pulse(update_pulse), .update_flag(update_flag));

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic wr(logic [2:0] sel, logic [15:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic force_upd();
    sw_update = 1'b1;
    @(negedge clk);
    sw_update = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected=<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 count", int'(count), 0);
    chk("R1 pulse", int'(update_pulse), 0);
    chk("R1 flag", int'(update_flag), 0);
    // R1: limit 0xFFFF, divider 0: counts every clock without wrapping
    cnt_en = 1'b1;
    repeat (20) @(negedge clk);
    chk("R1 default limit/divider", int'(count), 20);
    chk("R1 no event", int'(update_flag), 0);

    // R2 R3 R5 sweep
    for (int p = 0; p < 3; p++)
      for (int a = 1; a < 4; a++)
        for (int n = 0; n < 3; n++) begin
          int per;
          per = (n + 1) * (a + 1) * (p + 1);
          wr(3'd1, 16'(p));
          wr(3'd2, 16'(a));
          wr(3'd3, 16'(n));
          force_upd();
          for (int k = 0; k <= 2 * per; k++) begin
            chk("R2/R3 count", int'(count), (k / (p + 1)) % (a + 1));
            chk("R5 pulse", int'(update_pulse), (k % per == 0) ? 1 : 0);
            @(negedge clk);
          end
        end

    // R6 pending repetition value
    wr(3'd1, 16'd0); wr(3'd2, 16'd3); wr(3'd3, 16'd0);
    force_upd();
    wr(3'd3, 16'd2);
    for (int k = 1; k <= 17; k++) begin
      chk("R6 pulse", int'(update_pulse), (k == 4 || k == 16) ? 1 : 0);
      @(negedge clk);
    end

    // R7 pending divider value
    wr(3'd2, 16'd1); wr(3'd3, 16'd0);
    force_upd();
    wr(3'd1, 16'd2);
    for (int k = 1; k <= 9; k++) begin
      chk("R7 pulse", int'(update_pulse), (k == 2 || k == 8) ? 1 : 0);
      @(negedge clk);
    end

    // R8 forced update mid-run
    wr(3'd1, 16'd0); wr(3'd2, 16'd100);
    force_upd();
    repeat (7) @(negedge clk);
    chk("R8 pre count", int'(count), 7);
    force_upd();
    chk("R8 count cleared", int'(count), 0);
    chk("R8 pulse", int'(update_pulse), 1);
    @(negedge clk);
    chk("R8 pulse width", int'(update_pulse), 0);

    // R10 enable freeze
    repeat (4) @(negedge clk);
    chk("R10 before", int'(count), 5);
    cnt_en = 1'b0;
    repeat (10) @(negedge clk);
    chk("R10 frozen", int'(count), 5);
    cnt_en = 1'b1;
    @(negedge clk);
    chk("R10 resume", int'(count), 6);

    // R11 counter write
    wr(3'd0, 16'd50);
    chk("R11 loaded", int'(count), 50);
    @(negedge clk);
    chk("R11 continues", int'(count), 51);

    // R4 zero limit holds
    wr(3'd2, 16'd0);
    begin
      int held;
      held = int'(count);
      for (int k = 0; k < 20; k++) begin
        chk("R4 hold", int'(count), held);
        chk("R4 no pulse", int'(update_pulse), 0);
        @(negedge clk);
      end
    end

    // R9 flag
    chk("R9 sticky", int'(update_flag), 1);
    wr(3'd4, 16'd1);
    chk("R9 write 1 keeps", int'(update_flag), 1);
    wr(3'd4, 16'd0);
    chk("R9 cleared", int'(update_flag), 0);
    repeat (3) @(negedge clk);
    chk("R9 stays clear", int'(update_flag), 0);
    wr_en = 1'b1; wr_sel = 3'd4; wr_data = 16'd0; sw_update = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; sw_update = 1'b0;
    chk("R9 set wins", int'(update_flag), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule